// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether one memory access may proceed against a single page-table entry that has already been found. Three independent sources of protection are evaluated in parallel. The first is a page-protection code from the entry, read against the key bit of the segment. The second is a class mask indexed by a 5-bit class key stored in the entry. The third is a no-execute and guarded filter. The granted read/write/execute set is the bitwise AND of the three. The requested access type (load, store or fetch) is then tested against that set.

The requester presents the entry's second word, the segment's two key bits, the privilege state, the two authority mask words, two enable flags and the access type, together with a one-cycle strobe. One cycle later the block returns the granted set, an allow/deny decision and separate fault-cause flags that the exception logic can merge into its status word. Raising the exception and translating the address are handled elsewhere.

Top module: `page_perm_check`

## Requirements
- R1: All outputs are zero after reset. `rsp_valid_o` is high exactly in the cycle after a cycle with `req_valid_i` high. Between strobes, the permission, decision and cause outputs hold their last values whatever the inputs do.
- R2: The effective key bit is `seg_key_user_i` when `user_mode_i` is 1, and `seg_key_super_i` otherwise.
- R3: The 3-bit protection code is {entry bit 63, entry bits 1:0}, with bit 63 as its most significant bit.
- R4: With key 0, codes 0, 1 and 2 give read/write/execute, codes 3 and 6 give read/execute, and codes 4, 5 and 7 give nothing.
- R5: With key 1, code 2 gives read/write/execute, codes 1 and 3 give read/execute, and codes 0, 4, 5, 6 and 7 give nothing.
- R6: Entry bit 2 (no-execute) or entry bit 3 (guarded) removes execute permission only and leaves read and write untouched.
- R7: The class key is {entry bits 61:60, entry bits 11:9}, with bits 61:60 as its upper two bits. It selects bits [2*(31-key)+1 : 2*(31-key)] of `amr_i`. Field bit 1 removes write and field bit 0 removes read. When `class_chk_en_i` is 0 the class mask removes nothing.
- R8: When both `class_chk_en_i` and `fetch_mask_en_i` are 1, bit 0 of the same field position in `iamr_i` removes execute.
- R9: `perm_o` is {read, write, execute} from bit 2 down to bit 0 and is the AND of the three sources. The access encoding is 0 = load (needs read), 1 = store (needs write), 2 = fetch (needs execute), and 3 is treated as a load. `allow_o` is 1 when the needed bit is set, and every denial has at least one cause flag set.
- R10: On a denied fetch, `cause_noexec_o` is set when the no-execute/guard filter removed execute. Otherwise `cause_prot_o` is set when the protection code removed execute. `cause_class_o` is set independently when the class mask removed execute.
- R11: On a denied load or store, `cause_prot_o` is set when the protection code removed the needed bit, `cause_class_o` is set when the class mask removed it, and `cause_store_o` is set for a store. When access is allowed, all cause flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe; inputs are sampled in this cycle |
| pte_word_i | input | 64 | Second word of the page-table entry |
| user_mode_i | input | 1 | Processor is in problem (user) state |
| seg_key_user_i | input | 1 | Segment key bit used in user state |
| seg_key_super_i | input | 1 | Segment key bit used in supervisor state |
| amr_i | input | 64 | Data authority mask word |
| iamr_i | input | 64 | Instruction authority mask word |
| class_chk_en_i | input | 1 | Enables the class-key mask |
| fetch_mask_en_i | input | 1 | Enables the instruction mask |
| access_i | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 load |
| rsp_valid_o | output | 1 | Result valid, one cycle after the strobe |
| perm_o | output | 3 | Granted {read, write, execute} |
| allow_o | output | 1 | Requested access permitted |
| cause_prot_o | output | 1 | Denied by the protection code |
| cause_noexec_o | output | 1 | Fetch denied by no-execute/guard |
| cause_class_o | output | 1 | Denied by the class mask |
| cause_store_o | output | 1 | Denied access was a store |

## Verification
The directed cases sweep all eight protection codes under both key values, with the key bit chosen once through each privilege state. A swapped table entry or an inverted key select would therefore grant or drop a specific permission. The class mask is exercised at keys 0 and 31, the two ends where a mirrored field offset would read the wrong pair of bits, and once with the enable off, where a design that ignored the flag would still deny. Fetch denials that trip both the guard filter and the protection code check the cause priority: a design that reported both causes, or only the protection cause, is caught. Random traffic also changes inputs between strobes, so any design whose outputs do not hold stays visible.

// File: rtl/page_perm_pkg.sv
package page_perm_pkg;

    localparam int PTE_W      = 64;
    localparam int NOEXEC_BIT = 2;
    localparam int GUARD_BIT  = 3;
    localparam int CKEY_LO    = 9;
    localparam int CKEY_LO_W  = 3;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    typedef struct packed {
        logic prot;
        logic noexec;
        logic ckey;
        logic store;
    } cause_t;

    typedef struct packed {
        logic   valid;
        perm_t  perm;
        logic   allow;
        cause_t cause;
    } rsp_t;

endpackage

// File: rtl/page_perm_pp.sv
module page_perm_pp
    import page_perm_pkg::*;
(
    input  logic       key_i,
    input  logic [2:0] code_i,
    output perm_t      perm_o
);

    always_comb begin
        perm_o = perm_t'(3'b000);
        if (!key_i) begin
            case (code_i)
                3'd0, 3'd1, 3'd2: perm_o = perm_t'(3'b111);
                3'd3, 3'd6:       perm_o = perm_t'(3'b101);
                default:          perm_o = perm_t'(3'b000);
            endcase
        end else begin
            case (code_i)
                3'd2:       perm_o = perm_t'(3'b111);
                3'd1, 3'd3: perm_o = perm_t'(3'b101);
                default:    perm_o = perm_t'(3'b000);
            endcase
        end
    end

endmodule

// File: rtl/page_perm_class.sv
module page_perm_class
    import page_perm_pkg::*;
#(
    parameter int WORD_W = 64,
    localparam int NKEYS = WORD_W / 2,
    localparam int KEY_W = $clog2(NKEYS)
) (
    input  logic [WORD_W-1:0] amr_i,
    input  logic [WORD_W-1:0] iamr_i,
    input  logic [KEY_W-1:0]  key_i,
    input  logic              chk_en_i,
    input  logic              fetch_en_i,
    output perm_t             perm_o
);

    logic [1:0] amr_fld  [NKEYS];
    logic [1:0] iamr_fld [NKEYS];

    // key k owns the pair counted down from the most significant end
    for (genvar k = 0; k < NKEYS; k++) begin : g_fld
        assign amr_fld[k]  = amr_i[WORD_W-1-2*k -: 2];
        assign iamr_fld[k] = iamr_i[WORD_W-1-2*k -: 2];
    end

    always_comb begin
        perm_o = perm_t'(3'b111);
        if (chk_en_i) begin
            if (amr_fld[key_i][1]) perm_o.w = 1'b0;
            if (amr_fld[key_i][0]) perm_o.r = 1'b0;
            if (fetch_en_i && iamr_fld[key_i][0]) perm_o.x = 1'b0;
        end
    end

endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
    import page_perm_pkg::*;
#(
    parameter int WORD_W = PTE_W,
    localparam int NKEYS = WORD_W / 2,
    localparam int KEY_W = $clog2(NKEYS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [WORD_W-1:0] pte_word_i,
    input  logic              user_mode_i,
    input  logic              seg_key_user_i,
    input  logic              seg_key_super_i,
    input  logic [WORD_W-1:0] amr_i,
    input  logic [WORD_W-1:0] iamr_i,
    input  logic              class_chk_en_i,
    input  logic              fetch_mask_en_i,
    input  logic [1:0]        access_i,
    output logic              rsp_valid_o,
    output logic [2:0]        perm_o,
    output logic              allow_o,
    output logic              cause_prot_o,
    output logic              cause_noexec_o,
    output logic              cause_class_o,
    output logic              cause_store_o
);

    localparam int CODE_HI  = WORD_W - 1;
    localparam int CKEY_HI  = WORD_W - 3;
    localparam int CKEY_HI_W = KEY_W - CKEY_LO_W;

    logic               key_bit;
    logic [2:0]         pp_code;
    logic [KEY_W-1:0]   class_key;
    perm_t              pp_perm;
    perm_t              cls_perm;
    perm_t              nx_perm;
    rsp_t               st_d, st_q;

    assign key_bit   = user_mode_i ? seg_key_user_i : seg_key_super_i;
    assign pp_code   = {pte_word_i[CODE_HI], pte_word_i[1:0]};
    assign class_key = {pte_word_i[CKEY_HI -: CKEY_HI_W],
                        pte_word_i[CKEY_LO +: CKEY_LO_W]};

    page_perm_pp u_pp (
        .key_i  (key_bit),
        .code_i (pp_code),
        .perm_o (pp_perm)
    );

    page_perm_class #(.WORD_W(WORD_W)) u_cls (
        .amr_i      (amr_i),
        .iamr_i     (iamr_i),
        .key_i      (class_key),
        .chk_en_i   (class_chk_en_i),
        .fetch_en_i (fetch_mask_en_i),
        .perm_o     (cls_perm)
    );

    always_comb begin
        nx_perm   = perm_t'(3'b111);
        nx_perm.x = ~(pte_word_i[NOEXEC_BIT] | pte_word_i[GUARD_BIT]);
    end

    always_comb begin
        perm_t need;
        perm_t grant;
        logic  is_fetch;

        st_d       = st_q;
        st_d.valid = 1'b0;

        is_fetch = (acc_e'(access_i) == ACC_FETCH);
        case (acc_e'(access_i))
            ACC_STORE: need = perm_t'(3'b010);
            ACC_FETCH: need = perm_t'(3'b001);
            default:   need = perm_t'(3'b100);
        endcase
        grant = pp_perm & cls_perm & nx_perm;

        if (req_valid_i) begin
            st_d.valid = 1'b1;
            st_d.perm  = grant;
            st_d.allow = |(need & grant);
            st_d.cause = '0;
            if (!st_d.allow) begin
                if (is_fetch) begin
                    st_d.cause.noexec = ~nx_perm.x;
                    st_d.cause.prot   = nx_perm.x & ~pp_perm.x;
                    st_d.cause.ckey   = ~cls_perm.x;
                end else begin
                    st_d.cause.prot  = |(need & ~pp_perm);
                    st_d.cause.ckey  = |(need & ~cls_perm);
                    st_d.cause.store = (acc_e'(access_i) == ACC_STORE);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rsp_valid_o    = st_q.valid;
    assign perm_o         = st_q.perm;
    assign allow_o        = st_q.allow;
    assign cause_prot_o   = st_q.cause.prot;
    assign cause_noexec_o = st_q.cause.noexec;
    assign cause_class_o  = st_q.cause.ckey;
    assign cause_store_o  = st_q.cause.store;

endmodule

// File: rtl/page_perm_check_sva.sv
module page_perm_check_sva #(
    parameter int WORD_W = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic [WORD_W-1:0] pte_word_i,
    input logic              class_chk_en_i,
    input logic [1:0]        access_i,
    input logic              rsp_valid_o,
    input logic [2:0]        perm_o,
    input logic              allow_o,
    input logic              cause_prot_o,
    input logic              cause_noexec_o,
    input logic              cause_class_o,
    input logic              cause_store_o
);

    logic [3:0] causes;
    assign causes = {cause_prot_o, cause_noexec_o, cause_class_o, cause_store_o};

    p_rsp_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o);

    p_rsp_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !rsp_valid_o);

    p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> ($stable(perm_o) && $stable(allow_o) && $stable(causes)));

    p_guard_x_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && (pte_word_i[2] || pte_word_i[3])) |=> !perm_o[0]);

    p_class_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !class_chk_en_i) |=> !cause_class_o);

    p_deny_has_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && !allow_o) |-> ($countones(causes) > 0));

    p_fetch_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> $onehot0({cause_noexec_o, cause_prot_o}));

    p_store_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && access_i != 2'd1) |=> !cause_store_o);

    p_allow_clean_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && allow_o) |-> (causes == 4'b0000));

endmodule

bind page_perm_check page_perm_check_sva #(.WORD_W(WORD_W)) u_sva (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .pte_word_i     (pte_word_i),
    .class_chk_en_i (class_chk_en_i),
    .access_i       (access_i),
    .rsp_valid_o    (rsp_valid_o),
    .perm_o         (perm_o),
    .allow_o        (allow_o),
    .cause_prot_o   (cause_prot_o),
    .cause_noexec_o (cause_noexec_o),
    .cause_class_o  (cause_class_o),
    .cause_store_o  (cause_store_o)
);

// File: tb/page_perm_check_bench.sv
module page_perm_check_bench;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [63:0] pte_word_i = '0;
    logic        user_mode_i = 1'b0;
    logic        seg_key_user_i = 1'b0;
    logic        seg_key_super_i = 1'b0;
    logic [63:0] amr_i = '0;
    logic [63:0] iamr_i = '0;
    logic        class_chk_en_i = 1'b0;
    logic        fetch_mask_en_i = 1'b0;
    logic [1:0]  access_i = 2'd0;
    logic        rsp_valid_o;
    logic [2:0]  perm_o;
    logic        allow_o;
    logic        cause_prot_o, cause_noexec_o, cause_class_o, cause_store_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [2:0] exp_perm;
    logic       exp_allow;
    logic [3:0] exp_cause;

    always #5 clk_i = ~clk_i;

    page_perm_check u_page_perm_check (.*);

    function automatic logic [2:0] ref_code(input logic key, input logic [2:0] code);
        if (!key) begin
            if (code <= 3'd2) return 3'b111;
            if (code == 3'd3 || code == 3'd6) return 3'b101;
            return 3'b000;
        end
        if (code == 3'd2) return 3'b111;
        if (code == 3'd1 || code == 3'd3) return 3'b101;
        return 3'b000;
    endfunction

    function automatic logic [2:0] ref_class(input logic [63:0] a, input logic [63:0] ia,
                                             input int key, input logic en, input logic fen);
        logic [2:0] p = 3'b111;
        int base = 2 * (31 - key);
        if (en) begin
            if (a[base+1]) p[1] = 1'b0;
            if (a[base])   p[2] = 1'b0;
            if (fen && ia[base]) p[0] = 1'b0;
        end
        return p;
    endfunction

    task automatic compute_expected();
        logic       key = user_mode_i ? seg_key_user_i : seg_key_super_i;
        logic [2:0] pp = ref_code(key, {pte_word_i[63], pte_word_i[1:0]});
        int         ck = {pte_word_i[61:60], pte_word_i[11:9]};
        logic [2:0] cl = ref_class(amr_i, iamr_i, ck, class_chk_en_i, fetch_mask_en_i);
        logic [2:0] nx = {2'b11, ~(pte_word_i[2] | pte_word_i[3])};
        logic [2:0] need;
        need = (access_i == 2'd1) ? 3'b010 : (access_i == 2'd2) ? 3'b001 : 3'b100;
        exp_perm  = pp & cl & nx;
        exp_allow = (need & exp_perm) != 0;
        exp_cause = 4'b0000;
        if (!exp_allow) begin
            if (access_i == 2'd2) begin
                exp_cause[2] = ~nx[0];
                exp_cause[3] = nx[0] & ~pp[0];
                exp_cause[1] = ~cl[0];
            end else begin
                exp_cause[3] = (need & ~pp) != 0;
                exp_cause[1] = (need & ~cl) != 0;
                exp_cause[0] = (access_i == 2'd1);
            end
        end
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] outs();
        return {rsp_valid_o, perm_o, allow_o,
                cause_prot_o, cause_noexec_o, cause_class_o} ;
    endfunction

    // send one request, check at the negedge after the capturing edge
    task automatic txn(input string tag);
        @(negedge clk_i);
        req_valid_i = 1'b1;
        compute_expected();
        @(negedge clk_i);
        req_valid_i = 1'b0;
        check({tag, " perm"}, {5'b0, perm_o}, {5'b0, exp_perm});
        check({tag, " allow/valid"}, {6'b0, rsp_valid_o, allow_o}, {6'b0, 1'b1, exp_allow});
        check({tag, " causes"},
              {4'b0, cause_prot_o, cause_noexec_o, cause_class_o, cause_store_o},
              {4'b0, exp_cause});
    endtask

    task automatic set_entry(input logic [2:0] code, input logic nx, input logic g,
                             input int ck);
        pte_word_i = '0;
        pte_word_i[63]    = code[2];
        pte_word_i[1:0]   = code[1:0];
        pte_word_i[2]     = nx;
        pte_word_i[3]     = g;
        pte_word_i[61:60] = ck[4:3];
        pte_word_i[11:9]  = ck[2:0];
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk_i);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        logic [7:0] held;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk_i);
        // R1: reset state
        check("R1 reset", {outs(), cause_store_o, 7'b0} >> 7, 9'b0 >> 7);
        check("R1 reset vector", outs(), 8'h00);
        rst_ni = 1'b1;

        // R2: key select through privilege state
        set_entry(3'd0, 0, 0, 0);
        seg_key_user_i = 1'b1; seg_key_super_i = 1'b0; access_i = 2'd0;
        user_mode_i = 1'b1; txn("R2 user key");
        check("R2 user key denies", {7'b0, allow_o}, 8'd0);
        user_mode_i = 1'b0; txn("R2 super key");
        check("R2 super key allows", {7'b0, allow_o}, 8'd1);

        // R3 R4 R5: sweep all codes under both keys
        for (int k = 0; k < 2; k++) begin
            for (int c = 0; c < 8; c++) begin
                set_entry(c[2:0], 0, 0, 0);
                user_mode_i = 1'b0; seg_key_super_i = k[0];
                access_i = 2'd2;
                txn(k == 0 ? "R4 key0 table" : "R5 key1 table");
            end
        end
        set_entry(3'd6, 0, 0, 0); seg_key_super_i = 1'b0;
        txn("R3 high code bit");
        check("R3 code 6 gives rx", {5'b0, perm_o}, 8'b101);

        // R6: no-execute / guarded
        set_entry(3'd0, 1, 0, 0); access_i = 2'd2; txn("R6 R10 noexec fetch");
        set_entry(3'd0, 0, 1, 0); access_i = 2'd1; txn("R6 guarded store");
        check("R6 rw kept", {5'b0, perm_o}, 8'b110);
        set_entry(3'd4, 1, 1, 0); access_i = 2'd2; txn("R10 prio noexec over code");
        check("R10 only noexec", {6'b0, cause_noexec_o, cause_prot_o}, 8'b10);

        // R7 R8: class key at both ends
        for (int ck = 0; ck < 32; ck += 31) begin
            set_entry(3'd0, 0, 0, ck);
            amr_i = '0; amr_i[2*(31-ck) +: 2] = 2'b11;
            iamr_i = '0; iamr_i[2*(31-ck)] = 1'b1;
            class_chk_en_i = 1'b1; fetch_mask_en_i = 1'b1;
            access_i = 2'd0; txn("R7 load blocked");
            access_i = 2'd1; txn("R7 R11 store blocked");
            access_i = 2'd2; txn("R8 fetch blocked");
            class_chk_en_i = 1'b0;
            access_i = 2'd1; txn("R7 disabled");
            check("R7 disabled allows", {7'b0, allow_o}, 8'd1);
        end
        amr_i = 64'hFFFF_FFFF_FFFF_FFFF; class_chk_en_i = 1'b1;
        set_entry(3'd3, 0, 0, 7); access_i = 2'd3; txn("R9 R11 alt access as load");

        // R1 hold plus random traffic
        for (int i = 0; i < 3000; i++) begin
            pte_word_i = {$urandom, $urandom};
            amr_i = {$urandom, $urandom};
            iamr_i = {$urandom, $urandom};
            {user_mode_i, seg_key_user_i, seg_key_super_i,
             class_chk_en_i, fetch_mask_en_i} = 5'($urandom);
            access_i = 2'($urandom);
            txn("R9 R10 R11 random");
            held = {perm_o, allow_o, cause_prot_o, cause_noexec_o, cause_class_o, cause_store_o};
            if (i % 10 == 0) begin
                pte_word_i = ~pte_word_i; amr_i = ~amr_i; access_i = ~access_i;
                @(negedge clk_i);
                check("R1 hold",
                      {perm_o, allow_o, cause_prot_o, cause_noexec_o, cause_class_o, cause_store_o},
                      held);
                check("R1 valid low", {7'b0, rsp_valid_o}, 8'd0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule